// File: doc/BRIEF.md
# In-Band XON/XOFF Flow-Control Engine

This block performs software flow control for a UART. It watches the received byte stream for programmed control characters. A recognised "stop" character holds the local transmitter, and a recognised "go" character releases it. Every byte that is not a control character passes on to the receive FIFO one cycle later.

In the other direction, the block watches the receive FIFO fill level. When the level rises above a high-water mark, it asks the serializer to send a stop character. When the level then drops below a low-water mark, it asks for a go character. The serializer accepts such a request only between bytes. While a request is waiting, ordinary data is not allowed to load.

A 4-bit mode input selects the behaviour. Bits 1:0 set how received characters are recognised and bits 3:2 set what is sent. Both 2-bit fields use the same encoding:

| Code | Characters used |
|------|-----------------|
| 00 | off |
| 10 | first set (XON1 and XOFF1) |
| 01 | second set (XON2 and XOFF2) |
| 11 | a two-character pair, first-set character then second-set character |

The block also drives a status byte and a maskable interrupt that flags recognised control characters.

**Receive matcher states.** RM_IDLE is the resting state. RM_ON_HALF means XON1 has been seen while in pair mode. RM_OFF_HALF means XOFF1 has been seen while in pair mode. The transitions are:
- RM_IDLE goes to RM_ON_HALF or RM_OFF_HALF on the matching first-set character.
- A half state goes back to RM_IDLE when the matching second-set character completes the pair.
- On any other byte, a half state re-evaluates that byte as if it were in RM_IDLE.
- Outside pair mode, the matcher stays in RM_IDLE.

**Transmit controller states.** TX_IDLE, TX_OFF_FIRST, TX_OFF_SECOND, TX_PAUSED, TX_ON_FIRST and TX_ON_SECOND. The transitions are:
- TX_IDLE goes to TX_OFF_FIRST when the level exceeds the high-water mark.
- Each send state advances when the serializer accepts the character. In pair mode, a FIRST state moves to its SECOND state. Otherwise it moves to TX_PAUSED after a stop character, or to TX_IDLE after a go character.
- TX_PAUSED goes to TX_ON_FIRST when the level falls below the low-water mark.
- Transmit mode 00 forces TX_IDLE from any state.

Top module: `swfc_engine`

## Requirements
- R1: Receive mode 10 recognises only XON1/XOFF1, and receive mode 01 recognises only XON2/XOFF2. A recognised stop character sets tx_hold_o from the next cycle. A recognised go character clears it.
- R2: In receive mode 11, a stop is recognised only when XOFF1 is immediately followed by XOFF2, and a go only when XON1 is immediately followed by XON2. Any other byte resets the pairing and is itself re-evaluated as a possible first character.
- R3: Each received byte appears on rx_fwd_valid_o/rx_fwd_byte_o one cycle later, except a recognised control character, which is consumed. In pair mode the first character of a pair is forwarded and the completing second character is consumed.
- R4: With receive mode 00, no character is recognised, every byte is forwarded, and tx_hold_o is cleared.
- R5: When xon_any_i is high, any received byte releases a held transmitter, except a byte that is itself a recognised stop character.
- R6: In TX_IDLE with a non-zero transmit mode, a level above hi_water_i requests a stop character. After it is sent, status bit 4 is set. A level below lo_water_i then requests a go character, and status bit 4 clears once that is sent.
- R7: Transmit mode 10 sends XOFF1/XON1, and mode 01 sends XOFF2/XON2. Mode 11 sends XOFF1 then XOFF2, or XON1 then XON2, with each character taken by a separate inj_ack_i.
- R8: A stop character is sent once per crossing of the high-water mark, however long the level stays high. A go character is sent only after a stop character.
- R9: inj_valid_o is never high while ser_busy_i is high. data_ok_o is low while the serializer is busy, while a control request is pending, or while the transmitter is held.
- R10: status_o has bit 0 = CTS hold, bit 1 = DSR hold, bit 3 = held by a received stop character, and bit 4 = stop character sent. All other bits are 0.
- R11: A recognised control character latches an interrupt pending flag, and irq_clr_i clears it. irq_o is the pending flag gated by irq_en_i. irq_id_o is 8'h10 while irq_o is high and 8'h01 otherwise.
- R12: Transmit mode 00 withdraws any pending request and clears the stop-sent status from the next cycle.
- R13: After reset, the matcher is idle and the transmit controller is in TX_IDLE. All of the following are 0: the hold, the forwarding output, inject requests, interrupt and status bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Bits 1:0 receive mode, bits 3:2 transmit mode |
| xon_any_i | input | 1 | Any received byte releases the hold |
| xon1_i | input | CHAR_W | First-set go character |
| xon2_i | input | CHAR_W | Second-set go character |
| xoff1_i | input | CHAR_W | First-set stop character |
| xoff2_i | input | CHAR_W | Second-set stop character |
| hi_water_i | input | LVL_W | High-water mark |
| lo_water_i | input | LVL_W | Low-water mark |
| fifo_level_i | input | LVL_W | Receive FIFO fill level |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | CHAR_W | Received byte |
| ser_busy_i | input | 1 | Serializer is shifting a byte |
| inj_ack_i | input | 1 | Serializer took the control character |
| cts_hold_i | input | 1 | Transmit held by CTS |
| dsr_hold_i | input | 1 | Transmit held by DSR |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Clear the pending interrupt |
| rx_fwd_valid_o | output | 1 | Byte for the receive FIFO is valid |
| rx_fwd_byte_o | output | CHAR_W | Byte for the receive FIFO |
| tx_hold_o | output | 1 | Transmitter held by a received stop character |
| data_ok_o | output | 1 | Serializer may load a data byte |
| inj_valid_o | output | 1 | Control character request |
| inj_char_o | output | CHAR_W | Control character to send |
| status_o | output | 8 | Flow status byte |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 8 | Interrupt identification |

## Verification
The assertions check the following on every cycle:
- the serializer interlock and the priority of control requests over data;
- that a first-set stop character in mode 10 is consumed and holds the transmitter;
- that the off modes clear the hold and the stop-sent flag;
- the interrupt masking and the interrupt code.

Pair matching and its re-evaluation after a broken pair, the choice of characters per mode, the once-per-crossing behaviour of the threshold hysteresis, the release on any byte, and the two-acknowledge sequences can only be shown by the bench's ordered byte streams and level sweeps.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

    // Character-set selection, shared by the receive and transmit fields
    typedef enum logic [1:0] {
        CS_NONE = 2'b00,
        CS_SET2 = 2'b01,
        CS_SET1 = 2'b10,
        CS_PAIR = 2'b11
    } chset_e;

    typedef enum logic [1:0] {
        RM_IDLE,
        RM_ON_HALF,
        RM_OFF_HALF
    } rxm_state_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_OFF_FIRST,
        TX_OFF_SECOND,
        TX_PAUSED,
        TX_ON_FIRST,
        TX_ON_SECOND
    } txc_state_e;

    localparam int ST_CTS_BIT       = 0;
    localparam int ST_DSR_BIT       = 1;
    localparam int ST_XOFF_HELD_BIT = 3;
    localparam int ST_XOFF_SENT_BIT = 4;

    localparam logic [7:0] IRQ_ID_FLOWCHAR = 8'h10;
    localparam logic [7:0] IRQ_ID_NONE     = 8'h01;

endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
    import swfc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chset_e            mode_i,
    input  logic              xon_any_i,
    input  logic [CHAR_W-1:0] xon1_i,
    input  logic [CHAR_W-1:0] xon2_i,
    input  logic [CHAR_W-1:0] xoff1_i,
    input  logic [CHAR_W-1:0] xoff2_i,
    input  logic              rx_valid_i,
    input  logic [CHAR_W-1:0] rx_byte_i,
    output logic              fwd_valid_o,
    output logic [CHAR_W-1:0] fwd_byte_o,
    output logic              held_o,
    output logic              ctrl_hit_o
);

    rxm_state_e cur_q, nxt;
    logic on_hit, off_hit;
    logic pair_on_done, pair_off_done;
    logic held_q;

    // next-state and match decode
    always_comb begin
        nxt           = cur_q;
        on_hit        = 1'b0;
        off_hit       = 1'b0;
        pair_on_done  = 1'b0;
        pair_off_done = 1'b0;
        if (rx_valid_i) begin
            unique case (mode_i)
                CS_NONE: nxt = RM_IDLE;
                CS_SET1: begin
                    nxt     = RM_IDLE;
                    off_hit = (rx_byte_i == xoff1_i);
                    on_hit  = !off_hit && (rx_byte_i == xon1_i);
                end
                CS_SET2: begin
                    nxt     = RM_IDLE;
                    off_hit = (rx_byte_i == xoff2_i);
                    on_hit  = !off_hit && (rx_byte_i == xon2_i);
                end
                CS_PAIR: begin
                    pair_off_done = (cur_q == RM_OFF_HALF) && (rx_byte_i == xoff2_i);
                    pair_on_done  = (cur_q == RM_ON_HALF) && (rx_byte_i == xon2_i);
                    if (pair_off_done) begin
                        off_hit = 1'b1;
                        nxt     = RM_IDLE;
                    end else if (pair_on_done) begin
                        on_hit = 1'b1;
                        nxt    = RM_IDLE;
                    end else if (rx_byte_i == xoff1_i) begin
                        nxt = RM_OFF_HALF;
                    end else if (rx_byte_i == xon1_i) begin
                        nxt = RM_ON_HALF;
                    end else begin
                        nxt = RM_IDLE;
                    end
                end
            endcase
        end else if (mode_i != CS_PAIR) begin
            nxt = RM_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= RM_IDLE;
        else        cur_q <= nxt;
    end

    // output registers: hold flag and forwarded byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q      <= 1'b0;
            fwd_valid_o <= 1'b0;
            fwd_byte_o  <= '0;
        end else begin
            if (mode_i == CS_NONE)             held_q <= 1'b0;
            else if (off_hit)                  held_q <= 1'b1;
            else if (on_hit)                   held_q <= 1'b0;
            else if (rx_valid_i && xon_any_i)  held_q <= 1'b0;
            fwd_valid_o <= rx_valid_i && !(on_hit || off_hit);
            if (rx_valid_i) fwd_byte_o <= rx_byte_i;
        end
    end

    assign held_o     = held_q;
    assign ctrl_hit_o = on_hit || off_hit;

endmodule

// File: rtl/swfc_tx_ctrl.sv
module swfc_tx_ctrl
    import swfc_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chset_e            mode_i,
    input  logic [CHAR_W-1:0] xon1_i,
    input  logic [CHAR_W-1:0] xon2_i,
    input  logic [CHAR_W-1:0] xoff1_i,
    input  logic [CHAR_W-1:0] xoff2_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [LVL_W-1:0]  hi_i,
    input  logic [LVL_W-1:0]  lo_i,
    input  logic              ser_busy_i,
    input  logic              ack_i,
    output logic              req_pending_o,
    output logic              inj_valid_o,
    output logic [CHAR_W-1:0] inj_char_o,
    output logic              xoff_sent_o
);

    txc_state_e cur_q, nxt;
    logic above_hi, below_lo, taken, is_pair;
    logic [CHAR_W-1:0] off_first, on_first;

    assign above_hi  = level_i > hi_i;
    assign below_lo  = level_i < lo_i;
    assign is_pair   = (mode_i == CS_PAIR);
    assign taken     = inj_valid_o && ack_i;
    assign off_first = (mode_i == CS_SET2) ? xoff2_i : xoff1_i;
    assign on_first  = (mode_i == CS_SET2) ? xon2_i  : xon1_i;

    // next-state
    always_comb begin
        nxt = cur_q;
        if (mode_i == CS_NONE) begin
            nxt = TX_IDLE;
        end else begin
            unique case (cur_q)
                TX_IDLE:       if (above_hi) nxt = TX_OFF_FIRST;
                TX_OFF_FIRST:  if (taken)    nxt = is_pair ? TX_OFF_SECOND : TX_PAUSED;
                TX_OFF_SECOND: if (taken)    nxt = TX_PAUSED;
                TX_PAUSED:     if (below_lo) nxt = TX_ON_FIRST;
                TX_ON_FIRST:   if (taken)    nxt = is_pair ? TX_ON_SECOND : TX_IDLE;
                TX_ON_SECOND:  if (taken)    nxt = TX_IDLE;
                default:                     nxt = TX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= TX_IDLE;
        else        cur_q <= nxt;
    end

    // outputs
    always_comb begin
        req_pending_o = 1'b0;
        inj_char_o    = '0;
        xoff_sent_o   = 1'b0;
        unique case (cur_q)
            TX_IDLE: ;
            TX_OFF_FIRST: begin
                req_pending_o = 1'b1;
                inj_char_o    = off_first;
            end
            TX_OFF_SECOND: begin
                req_pending_o = 1'b1;
                inj_char_o    = xoff2_i;
            end
            TX_PAUSED: xoff_sent_o = 1'b1;
            TX_ON_FIRST: begin
                req_pending_o = 1'b1;
                inj_char_o    = on_first;
                xoff_sent_o   = 1'b1;
            end
            TX_ON_SECOND: begin
                req_pending_o = 1'b1;
                inj_char_o    = xon2_i;
                xoff_sent_o   = 1'b1;
            end
            default: ;
        endcase
        inj_valid_o = req_pending_o && !ser_busy_i;
    end

endmodule

// File: rtl/swfc_irq.sv
module swfc_irq
    import swfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic       clr_i,
    input  logic       en_i,
    output logic       irq_o,
    output logic [7:0] id_o
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (set_i) pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign irq_o = pend_q && en_i;
    assign id_o  = irq_o ? IRQ_ID_FLOWCHAR : IRQ_ID_NONE;

endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
    import swfc_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_i,
    input  logic              xon_any_i,
    input  logic [CHAR_W-1:0] xon1_i,
    input  logic [CHAR_W-1:0] xon2_i,
    input  logic [CHAR_W-1:0] xoff1_i,
    input  logic [CHAR_W-1:0] xoff2_i,
    input  logic [LVL_W-1:0]  hi_water_i,
    input  logic [LVL_W-1:0]  lo_water_i,
    input  logic [LVL_W-1:0]  fifo_level_i,
    input  logic              rx_valid_i,
    input  logic [CHAR_W-1:0] rx_byte_i,
    input  logic              ser_busy_i,
    input  logic              inj_ack_i,
    input  logic              cts_hold_i,
    input  logic              dsr_hold_i,
    input  logic              irq_en_i,
    input  logic              irq_clr_i,
    output logic              rx_fwd_valid_o,
    output logic [CHAR_W-1:0] rx_fwd_byte_o,
    output logic              tx_hold_o,
    output logic              data_ok_o,
    output logic              inj_valid_o,
    output logic [CHAR_W-1:0] inj_char_o,
    output logic [7:0]        status_o,
    output logic              irq_o,
    output logic [7:0]        irq_id_o
);

    chset_e rx_mode, tx_mode;
    logic   ctrl_hit, req_pending, xoff_sent;

    assign rx_mode = chset_e'(mode_i[1:0]);
    assign tx_mode = chset_e'(mode_i[3:2]);

    swfc_rx_match #(.CHAR_W(CHAR_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (rx_mode),
        .xon_any_i  (xon_any_i),
        .xon1_i     (xon1_i),
        .xon2_i     (xon2_i),
        .xoff1_i    (xoff1_i),
        .xoff2_i    (xoff2_i),
        .rx_valid_i (rx_valid_i),
        .rx_byte_i  (rx_byte_i),
        .fwd_valid_o(rx_fwd_valid_o),
        .fwd_byte_o (rx_fwd_byte_o),
        .held_o     (tx_hold_o),
        .ctrl_hit_o (ctrl_hit)
    );

    swfc_tx_ctrl #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (tx_mode),
        .xon1_i       (xon1_i),
        .xon2_i       (xon2_i),
        .xoff1_i      (xoff1_i),
        .xoff2_i      (xoff2_i),
        .level_i      (fifo_level_i),
        .hi_i         (hi_water_i),
        .lo_i         (lo_water_i),
        .ser_busy_i   (ser_busy_i),
        .ack_i        (inj_ack_i),
        .req_pending_o(req_pending),
        .inj_valid_o  (inj_valid_o),
        .inj_char_o   (inj_char_o),
        .xoff_sent_o  (xoff_sent)
    );

    swfc_irq u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(ctrl_hit),
        .clr_i(irq_clr_i),
        .en_i (irq_en_i),
        .irq_o(irq_o),
        .id_o (irq_id_o)
    );

    assign data_ok_o = !ser_busy_i && !req_pending && !tx_hold_o;

    always_comb begin
        status_o                   = '0;
        status_o[ST_CTS_BIT]       = cts_hold_i;
        status_o[ST_DSR_BIT]       = dsr_hold_i;
        status_o[ST_XOFF_HELD_BIT] = tx_hold_o;
        status_o[ST_XOFF_SENT_BIT] = xoff_sent;
    end

endmodule

// File: rtl/swfc_engine_chk.sv
module swfc_engine_chk #(
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        mode_i,
    input logic [CHAR_W-1:0] xoff1_i,
    input logic              rx_valid_i,
    input logic [CHAR_W-1:0] rx_byte_i,
    input logic              ser_busy_i,
    input logic              irq_en_i,
    input logic              rx_fwd_valid_o,
    input logic              tx_hold_o,
    input logic              data_ok_o,
    input logic              inj_valid_o,
    input logic [7:0]        status_o,
    input logic              irq_o,
    input logic [7:0]        irq_id_o,
    input logic [LVL_W-1:0]  fifo_level_i
);

    logic unused_lvl;
    assign unused_lvl = ^fifo_level_i;

    // R9
    busy_blocks_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_busy_i |-> (!inj_valid_o && !data_ok_o));

    // R9
    inject_over_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid_o |-> !data_ok_o);

    // R9
    held_blocks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hold_o |-> !data_ok_o);

    // R1
    set1_stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && mode_i[1:0] == 2'b10 && rx_byte_i == xoff1_i) |=> tx_hold_o);

    // R3
    stop_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && mode_i[1:0] == 2'b10 && rx_byte_i == xoff1_i) |=> !rx_fwd_valid_o);

    // R4
    rx_off_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1:0] == 2'b00) |=> !tx_hold_o);

    // R12
    tx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[3:2] == 2'b00) |=> (!inj_valid_o && !status_o[4]));

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);

    // R11
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_id_o == 8'h10));

endmodule

bind swfc_engine swfc_engine_chk #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_swfc_engine.sv
`timescale 1ns/1ps
module sim_swfc_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_i = '0;
    logic       xon_any_i = 1'b0;
    logic [7:0] xon1_i = 8'h11, xon2_i = 8'h91, xoff1_i = 8'h13, xoff2_i = 8'h93;
    logic [8:0] hi_water_i = 9'd8, lo_water_i = 9'd4, fifo_level_i = '0;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_byte_i = '0;
    logic       ser_busy_i = 1'b0, inj_ack_i = 1'b0;
    logic       cts_hold_i = 1'b0, dsr_hold_i = 1'b0;
    logic       irq_en_i = 1'b0, irq_clr_i = 1'b0;
    logic       rx_fwd_valid_o, tx_hold_o, data_ok_o, inj_valid_o, irq_o;
    logic [7:0] rx_fwd_byte_o, inj_char_o, status_o, irq_id_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    swfc_engine u0 (.*);

    // {rx mode[1:0], xon_any, byte[7:0], expect forwarded, expect hold}
    localparam int NV = 21;
    localparam logic [12:0] VEC [NV] = '{
        {2'b10, 1'b0, 8'h41, 1'b1, 1'b0},  // R1 plain data
        {2'b10, 1'b0, 8'h13, 1'b0, 1'b1},  // R1 R3 XOFF1 held, consumed
        {2'b10, 1'b0, 8'h41, 1'b1, 1'b1},
        {2'b10, 1'b0, 8'h93, 1'b1, 1'b1},  // R1 second set ignored
        {2'b10, 1'b0, 8'h11, 1'b0, 1'b0},  // R1 XON1 release
        {2'b01, 1'b0, 8'h13, 1'b1, 1'b0},  // R1 first set ignored
        {2'b01, 1'b0, 8'h93, 1'b0, 1'b1},
        {2'b01, 1'b0, 8'h91, 1'b0, 1'b0},
        {2'b11, 1'b0, 8'h13, 1'b1, 1'b0},  // R2 half pair forwarded
        {2'b11, 1'b0, 8'h93, 1'b0, 1'b1},  // R2 pair done
        {2'b11, 1'b0, 8'h11, 1'b1, 1'b1},
        {2'b11, 1'b0, 8'h42, 1'b1, 1'b1},  // R2 broken pair
        {2'b11, 1'b0, 8'h91, 1'b1, 1'b1},  // R2 lone second char
        {2'b11, 1'b0, 8'h11, 1'b1, 1'b1},
        {2'b11, 1'b0, 8'h11, 1'b1, 1'b1},  // R2 re-evaluated as first
        {2'b11, 1'b0, 8'h91, 1'b0, 1'b0},  // R2 R3 go pair consumed
        {2'b10, 1'b1, 8'h13, 1'b0, 1'b1},
        {2'b10, 1'b1, 8'h13, 1'b0, 1'b1},  // R5 stop still holds
        {2'b10, 1'b1, 8'h55, 1'b1, 1'b0},  // R5 any byte releases
        {2'b10, 1'b0, 8'h13, 1'b0, 1'b1},
        {2'b00, 1'b0, 8'h13, 1'b1, 1'b0}   // R4 off: forwarded, released
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ack_once();
        inj_ack_i = 1'b1;
        @(negedge clk);
        inj_ack_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 hold", tx_hold_o, 0);
        check("R13 fwd", rx_fwd_valid_o, 0);
        check("R13 inject", inj_valid_o, 0);
        check("R13 irq", irq_o, 0);
        check("R13 status", status_o, 8'h00);
        check("R13 data_ok", data_ok_o, 1);

        // receive table
        for (int i = 0; i < NV; i++) begin
            mode_i     = {2'b00, VEC[i][12:11]};
            xon_any_i  = VEC[i][10];
            rx_byte_i  = VEC[i][9:2];
            rx_valid_i = 1'b1;
            @(negedge clk);
            check($sformatf("R1/R2/R3/R4/R5 row %0d fwd", i), rx_fwd_valid_o, VEC[i][1]);
            if (VEC[i][1]) check($sformatf("R3 row %0d byte", i), rx_fwd_byte_o, VEC[i][9:2]);
            check($sformatf("R1/R2/R5 row %0d hold", i), tx_hold_o, VEC[i][0]);
        end
        rx_valid_i = 1'b0;
        xon_any_i  = 1'b0;
        @(negedge clk);

        // R11 interrupt
        check("R11 masked", irq_o, 0);
        check("R11 id none", irq_id_o, 8'h01);
        irq_en_i = 1'b1;
        @(negedge clk);
        check("R11 raised", irq_o, 1);
        check("R11 id", irq_id_o, 8'h10);
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        check("R11 cleared", irq_o, 0);

        // R10 status and R9 hold gating
        cts_hold_i = 1'b1;
        mode_i = 4'b0010;
        rx_byte_i = 8'h13; rx_valid_i = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0;
        check("R10 status held", status_o, 8'h09);
        check("R9 data blocked by hold", data_ok_o, 0);
        check("R11 raised again", irq_o, 1);
        cts_hold_i = 1'b0; dsr_hold_i = 1'b1;
        mode_i = 4'b0000;
        @(negedge clk);
        check("R10 status dsr", status_o, 8'h02);
        dsr_hold_i = 1'b0;

        // transmit, set 1
        mode_i = 4'b1000; fifo_level_i = 9'd0;
        @(negedge clk);
        check("R8 no XON before XOFF", inj_valid_o, 0);
        fifo_level_i = 9'd8;
        @(negedge clk);
        check("R6 at mark no request", inj_valid_o, 0);
        fifo_level_i = 9'd9; ser_busy_i = 1'b1;
        @(negedge clk);
        check("R9 busy blocks inject", inj_valid_o, 0);
        check("R9 busy blocks data", data_ok_o, 0);
        ser_busy_i = 1'b0;
        @(negedge clk);
        check("R6 XOFF request", inj_valid_o, 1);
        check("R7 XOFF1 char", inj_char_o, 8'h13);
        check("R9 request over data", data_ok_o, 0);
        ack_once();
        check("R6 sent status", status_o[4], 1);
        check("R6 no request", inj_valid_o, 0);
        repeat (3) @(negedge clk);
        check("R8 once per crossing", inj_valid_o, 0);
        fifo_level_i = 9'd4;
        @(negedge clk);
        check("R6 at low mark no XON", inj_valid_o, 0);
        fifo_level_i = 9'd3;
        @(negedge clk);
        check("R6 XON request", inj_valid_o, 1);
        check("R7 XON1 char", inj_char_o, 8'h11);
        ack_once();
        check("R6 sent cleared", status_o[4], 0);
        check("R6 idle", inj_valid_o, 0);

        // transmit, pair
        mode_i = 4'b1100; fifo_level_i = 9'd9;
        @(negedge clk);
        check("R7 pair XOFF first", inj_char_o, 8'h13);
        ack_once();
        check("R7 pair XOFF second valid", inj_valid_o, 1);
        check("R7 pair XOFF second", inj_char_o, 8'h93);
        ack_once();
        check("R7 pair paused", status_o[4], 1);
        fifo_level_i = 9'd0;
        @(negedge clk);
        check("R7 pair XON first", inj_char_o, 8'h11);
        ack_once();
        check("R7 pair XON second", inj_char_o, 8'h91);
        ack_once();
        check("R7 pair done", inj_valid_o, 0);

        // transmit, set 2, then off
        mode_i = 4'b0100; fifo_level_i = 9'd9;
        @(negedge clk);
        check("R7 XOFF2 char", inj_char_o, 8'h93);
        ack_once();
        check("R7 set2 sent", status_o[4], 1);
        mode_i = 4'b0000;
        @(negedge clk);
        check("R12 sent cleared", status_o[4], 0);
        check("R12 no request", inj_valid_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule